// File: doc/BRIEF.md
# Capture/Compare Timer Channel

This block is one timer channel: an up-counter that advances on count events, plus a small bank of general registers beside it. Each general register works either as a compare register, which raises a one-cycle match pulse when the counter reaches its value, or as a capture register, which records the counter value when an edge arrives on its own capture pin. Configuration comes in as static register-style inputs:
- a start bit;
- a 3-bit clock source;
- a 2-bit edge select for the external clock and the capture pins;
- a 3-bit clear select.

The clear select picks which compare register sets the counting period. One encoding of it leaves the counter free-running, with an overflow pulse at each wrap.

Everything runs on one system clock. Internal counting rates are single-cycle enables from a free-running divider. The external clock pin and the capture pins pass through two synchronising flops, and edges are found against the previous sample. A host loads a general register through a write strobe, and reads every register back on a flat output bus.

Top module: `tmr_channel`

## Requirements
- R1: The counter only counts upward. It changes by exactly +1, or to zero when cleared, on each count event. A count event is a cycle with the start bit high and an event from the selected clock source.
- R2: While the start bit is 0 the counter holds its value, whatever the clock source or external pin does.
- R3: A clock source value k of 0, 1, 2 or 3 gives one count event every 1, 4, 16 or 64 system cycles. Any value from 4 to 7 selects the external clock pin.
- R4: The 2-bit edge select encodes 00 as rising edges, 01 as falling edges, and 10 or 11 as both edges. It applies to the synchronised external clock and, through its own input, to the capture pins.
- R5: With clear select 0 the counter free-runs and wraps from all ones to zero. The overflow output pulses high for exactly the one cycle in which the counter first reads zero after the wrap.
- R6: A clear select k from 1 to the number of registers names general register k-1 as the clearing register. A count event that finds the counter equal to that register sends the counter to zero, so the counting period is the register value plus one.
- R7: The clearing register clears the counter only while it is in compare mode. In capture mode the counter runs past its value.
- R8: The match output of a compare-mode register pulses for one cycle, in the cycle after a count event that found the counter equal to the register. Capture-mode registers never raise their match output.
- R9: For a capture-mode register, an edge on its capture pin stores a counter value into the register and pulses its capture output for one cycle. The stored value is the one the counter holds after the second system clock edge following the pin change. The store and the pulse appear after the third edge.
- R10: Capture pins have no effect on compare-mode registers. A host write loads the register. A write in the same cycle as a capture wins and suppresses the capture pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Counter run enable |
| clk_sel_i | input | 3 | Counter clock source |
| clk_edge_i | input | 2 | Counting edge of the external clock |
| clr_sel_i | input | 3 | Counter clearing source (0 = free-running) |
| ext_clk_i | input | 1 | External clock pin |
| cap_mode_i | input | NUM_GR | Per register: 1 = capture, 0 = compare |
| cap_edge_i | input | 2 | Capture edge select |
| cap_in_i | input | NUM_GR | Capture pins, one per register |
| gr_wr_i | input | NUM_GR | Per-register write strobe |
| gr_wdata_i | input | CNT_W | Write data for the general registers |
| cnt_o | output | CNT_W | Current counter value |
| gr_o | output | NUM_GR*CNT_W | All general registers, register i at bits i*CNT_W upward |
| match_o | output | NUM_GR | Compare-match pulses |
| capture_o | output | NUM_GR | Capture pulses |
| ovf_o | output | 1 | Overflow pulse |

## Verification
The hardest case is a capture that lands in the same cycle as a host write to that register. The synchroniser delay hides the moment at which the capture acts. The bench counts the two synchroniser edges from a pin change made between clock edges, then raises the write strobe so that it meets the capture edge exactly. A second hard point is the period of the periodic mode. The counter may be far above the new period value when the mode changes, so the bench first waits out the wrap to the first match, then measures the spacing of the following matches for every clearing register.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    // Edge select encoding shared by external clock and capture pins
    localparam logic [1:0] EDGE_RISE = 2'b00;
    localparam logic [1:0] EDGE_FALL = 2'b01;

    // Clear select value meaning free-running operation
    localparam logic [2:0] CLR_NONE = 3'd0;

    function automatic logic edge_hit(input logic rise, input logic fall, input logic [1:0] sel);
        logic hit;
        case (sel)
            EDGE_RISE: hit = rise;
            EDGE_FALL: hit = fall;
            default:   hit = rise | fall;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int STEP_LOG2 = 2,
    parameter int NUM_RATIO = 4
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    output logic [NUM_RATIO-1:0] en_o
);
    localparam int PRE_W = STEP_LOG2 * (NUM_RATIO - 1);

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + PRE_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) pre_q <= '0;
        else         pre_q <= pre_d;
    end

    // Ratio r fires once every 2**(r*STEP_LOG2) cycles
    assign en_o[0] = 1'b1;
    for (genvar r = 1; r < NUM_RATIO; r++) begin : g_ratio
        assign en_o[r] = &pre_q[r*STEP_LOG2-1:0];
    end

endmodule

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
    parameter int LANES = 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [LANES-1:0] pin_i,
    output logic [LANES-1:0] rise_o,
    output logic [LANES-1:0] fall_o
);
    typedef struct packed {
        logic [LANES-1:0] s1;
        logic [LANES-1:0] s2;
        logic [LANES-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign rise_o[l] =  st_q.s2[l] & ~st_q.prev[l];
        assign fall_o[l] = ~st_q.s2[l] &  st_q.prev[l];
    end

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel #(
    parameter int CNT_W     = 16,
    parameter int NUM_GR    = 4,
    parameter int STEP_LOG2 = 2,
    parameter int NUM_RATIO = 4
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    start_i,
    input  logic [2:0]              clk_sel_i,
    input  logic [1:0]              clk_edge_i,
    input  logic [2:0]              clr_sel_i,
    input  logic                    ext_clk_i,
    input  logic [NUM_GR-1:0]       cap_mode_i,
    input  logic [1:0]              cap_edge_i,
    input  logic [NUM_GR-1:0]       cap_in_i,
    input  logic [NUM_GR-1:0]       gr_wr_i,
    input  logic [CNT_W-1:0]        gr_wdata_i,
    output logic [CNT_W-1:0]        cnt_o,
    output logic [NUM_GR*CNT_W-1:0] gr_o,
    output logic [NUM_GR-1:0]       match_o,
    output logic [NUM_GR-1:0]       capture_o,
    output logic                    ovf_o
);
    import tmr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0]             cnt;
        logic                         ovf;
        logic [NUM_GR-1:0]            match;
        logic [NUM_GR-1:0]            cap;
        logic [NUM_GR-1:0][CNT_W-1:0] gr;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_RATIO-1:0] pre_en;
    logic                 ext_rise, ext_fall;
    logic [NUM_GR-1:0]    cap_rise, cap_fall;

    tmr_prescale #(
        .STEP_LOG2(STEP_LOG2),
        .NUM_RATIO(NUM_RATIO)
    ) prescale_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .en_o  (pre_en)
    );

    tmr_edge_sync #(.LANES(1)) ext_sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (ext_clk_i),
        .rise_o(ext_rise),
        .fall_o(ext_fall)
    );

    tmr_edge_sync #(.LANES(NUM_GR)) cap_sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .pin_i (cap_in_i),
        .rise_o(cap_rise),
        .fall_o(cap_fall)
    );

    logic src_ev;
    logic tick;
    logic clr_hit;
    logic cap_hit;

    always_comb begin
        st_d = st_q;

        // Clock source: internal ratios below NUM_RATIO, external pin above
        src_ev = edge_hit(ext_rise, ext_fall, clk_edge_i);
        for (int r = 0; r < NUM_RATIO; r++) begin
            if (int'(clk_sel_i) == r) src_ev = pre_en[r];
        end
        tick = start_i & src_ev;

        // Clearing register must be in compare mode and equal to the counter
        clr_hit = 1'b0;
        for (int i = 0; i < NUM_GR; i++) begin
            if (clr_sel_i != CLR_NONE && int'(clr_sel_i) == i + 1 &&
                !cap_mode_i[i] && st_q.cnt == st_q.gr[i]) begin
                clr_hit = 1'b1;
            end
        end

        if (tick) st_d.cnt = clr_hit ? '0 : st_q.cnt + CNT_W'(1);
        st_d.ovf = tick & ~clr_hit & (st_q.cnt == CNT_MAX);

        for (int i = 0; i < NUM_GR; i++) begin
            cap_hit       = cap_mode_i[i] & edge_hit(cap_rise[i], cap_fall[i], cap_edge_i);
            st_d.match[i] = tick & ~cap_mode_i[i] & (st_q.cnt == st_q.gr[i]);
            st_d.cap[i]   = cap_hit & ~gr_wr_i[i];
            if (gr_wr_i[i])   st_d.gr[i] = gr_wdata_i;
            else if (cap_hit) st_d.gr[i] = st_q.cnt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cnt_o     = st_q.cnt;
    assign gr_o      = st_q.gr;
    assign match_o   = st_q.match;
    assign capture_o = st_q.cap;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/tmr_channel_chk.sv
`timescale 1ns/1ps
module tmr_channel_chk #(
    parameter int CNT_W  = 16,
    parameter int NUM_GR = 4
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic                    start_i,
    input logic [NUM_GR-1:0]       cap_mode_i,
    input logic [NUM_GR-1:0]       gr_wr_i,
    input logic [CNT_W-1:0]        cnt_o,
    input logic [NUM_GR*CNT_W-1:0] gr_o,
    input logic [NUM_GR-1:0]       match_o,
    input logic [NUM_GR-1:0]       capture_o,
    input logic                    ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    assert_hold_stopped_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> cnt_o == $past(cnt_o));

    assert_up_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + CNT_W'(1) || cnt_o == '0));

    assert_ovf_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o |-> (cnt_o == '0 && $past(cnt_o) == CNT_MAX));

    for (genvar i = 0; i < NUM_GR; i++) begin : g_reg
        assert_match_compare_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            match_o[i] |-> !$past(cap_mode_i[i]));

        assert_capture_value_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            capture_o[i] |-> gr_o[i*CNT_W +: CNT_W] == $past(cnt_o));

        assert_capture_mode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            capture_o[i] |-> ($past(cap_mode_i[i]) && !$past(gr_wr_i[i])));
    end

endmodule

bind tmr_channel tmr_channel_chk #(.CNT_W(CNT_W), .NUM_GR(NUM_GR)) chk_i (.*);

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;
    localparam int W = 8;
    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic [2:0]     clk_sel = 3'd0;
    logic [1:0]     clk_edge = 2'd0;
    logic [2:0]     clr_sel = 3'd0;
    logic           ext_clk = 1'b0;
    logic [N-1:0]   cap_mode = '0;
    logic [1:0]     cap_edge = 2'd0;
    logic [N-1:0]   cap_in = '0;
    logic [N-1:0]   gr_wr = '0;
    logic [W-1:0]   wdata = '0;
    logic [W-1:0]   cnt;
    logic [N*W-1:0] gr;
    logic [N-1:0]   match;
    logic [N-1:0]   capt;
    logic           ovf;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_channel #(.CNT_W(W), .NUM_GR(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .clk_sel_i(clk_sel),
        .clk_edge_i(clk_edge), .clr_sel_i(clr_sel), .ext_clk_i(ext_clk),
        .cap_mode_i(cap_mode), .cap_edge_i(cap_edge), .cap_in_i(cap_in),
        .gr_wr_i(gr_wr), .gr_wdata_i(wdata), .cnt_o(cnt), .gr_o(gr),
        .match_o(match), .capture_o(capt), .ovf_o(ovf)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int grv(input int i);
        return int'(gr[i*W +: W]);
    endfunction

    task automatic write_gr(input int i, input int v);
        @(negedge clk);
        gr_wr[i] = 1'b1;
        wdata = W'(v);
        @(negedge clk);
        gr_wr = '0;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int prev, last_pos, errs, bad_act, bad_exp, wraps, ovfs, maxc, seen;
        int vals[4];
        vals[0] = 0; vals[1] = 1; vals[2] = 5; vals[3] = 200;

        wait_n(5);
        rst_n = 1'b1;
        wait_n(1);
        chk("R1", "reset counter", cnt, 0);
        chk("R5", "reset overflow", ovf, 0);
        chk("R8", "reset match", match, 0);
        chk("R9", "reset capture", capt, 0);
        chk("R10", "reset registers", gr, 0);

        // R2: stopped counter holds
        wait_n(20);
        chk("R2", "hold while stopped from reset", cnt, 0);

        // R1/R3: spacing of count events for every internal ratio
        for (int r = 0; r < 4; r++) begin
            clk_sel = 3'(r);
            start = 1'b1;
            prev = cnt; last_pos = -1; errs = 0; bad_act = 0; bad_exp = 0;
            for (int c = 0; c < 400; c++) begin
                @(negedge clk);
                if (cnt != prev) begin
                    if (int'(cnt) != ((prev + 1) & 255)) begin errs++; bad_act = cnt; bad_exp = (prev + 1) & 255; end
                    if (last_pos >= 0 && (c - last_pos) != (1 << (2 * r))) begin
                        errs++; bad_act = c - last_pos; bad_exp = 1 << (2 * r);
                    end
                    last_pos = c;
                end
                prev = cnt;
            end
            chk("R3", $sformatf("ratio %0d event spacing", r), bad_act, bad_exp);
            chk("R1", $sformatf("ratio %0d step errors", r), errs, 0);
        end

        // R2: stop after running
        start = 1'b0;
        wait_n(2);
        prev = cnt;
        wait_n(30);
        chk("R2", "hold after stop", cnt, prev);

        // R5: free-running wrap and overflow pulse
        clk_sel = 3'd0; clr_sel = 3'd0; start = 1'b1;
        prev = cnt; wraps = 0; ovfs = 0; errs = 0;
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            if (prev == 255 && cnt == 0) wraps++;
            if (ovf) begin
                ovfs++;
                if (!(prev == 255 && cnt == 0)) errs++;
            end
            prev = cnt;
        end
        chk("R5", "wraps seen", wraps >= 2, 1);
        chk("R5", "overflow pulses per wrap", ovfs, wraps);
        chk("R5", "overflow misplaced", errs, 0);

        // R6/R8: periodic mode for every clearing register and several periods
        for (int k = 0; k < N; k++) begin
            for (int vi = 0; vi < 4; vi++) begin
                start = 1'b0;
                cap_mode = '0;
                write_gr(k, vals[vi]);
                chk("R10", $sformatf("write reg %0d", k), grv(k), vals[vi]);
                clr_sel = 3'(k + 1);
                start = 1'b1;
                seen = 0;
                for (int c = 0; c < 600 && seen == 0; c++) begin
                    @(negedge clk);
                    if (match[k]) seen = 1;
                end
                chk("R8", $sformatf("first match reg %0d", k), seen, 1);
                last_pos = 0; maxc = cnt; errs = 0; bad_act = vals[vi] + 1; wraps = 0;
                for (int c = 1; c < 800 && wraps < 3; c++) begin
                    @(negedge clk);
                    if (int'(cnt) > maxc) maxc = cnt;
                    if (match[k]) begin
                        wraps++;
                        if (c - last_pos != vals[vi] + 1) begin errs++; bad_act = c - last_pos; end
                        last_pos = c;
                    end
                end
                chk("R6", $sformatf("period reg %0d value %0d", k, vals[vi]), bad_act, vals[vi] + 1);
                chk("R6", $sformatf("peak count reg %0d value %0d", k, vals[vi]), maxc, vals[vi]);
            end
        end

        // R7: clearing register in capture mode does not clear
        start = 1'b0;
        write_gr(0, 5);
        cap_mode = 4'b0001; clr_sel = 3'd1; start = 1'b1;
        maxc = 0; seen = 0;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            if (int'(cnt) > maxc) maxc = cnt;
            if (match[0]) seen = 1;
        end
        chk("R7", "counter passes capture-mode clear value", maxc, 255);
        chk("R8", "no match from capture-mode register", seen, 0);
        chk("R7", "register kept", grv(0), 5);

        // R4: external clock edges
        cap_mode = '0; clr_sel = 3'd0;
        for (int e = 0; e < 3; e++) begin
            clk_sel = (e == 2) ? 3'd7 : 3'd4;
            clk_edge = 2'(e);
            start = 1'b1;
            wait_n(6);
            prev = cnt;
            repeat (7) begin
                ext_clk = 1'b1; wait_n(4);
                ext_clk = 1'b0; wait_n(4);
            end
            wait_n(6);
            chk("R4", $sformatf("external edges mode %0d", e), (int'(cnt) - prev) & 255, (e == 2) ? 14 : 7);
        end
        start = 1'b0;
        prev = cnt;
        repeat (5) begin
            ext_clk = 1'b1; wait_n(4);
            ext_clk = 1'b0; wait_n(4);
        end
        chk("R2", "external edges while stopped", cnt, prev);

        // R9: capture on rising, falling and both edges
        clk_sel = 3'd0; clr_sel = 3'd0; start = 1'b1; cap_mode = '1;
        for (int i = 0; i < N; i++) begin
            for (int ph = 0; ph < 4; ph++) begin
                cap_edge = (ph == 0) ? 2'd0 : (ph == 1) ? 2'd1 : 2'd2;
                @(negedge clk);
                cap_in[i] = (ph == 0 || ph == 2);
                @(negedge clk);
                @(negedge clk);
                prev = cnt;
                @(negedge clk);
                chk("R9", $sformatf("reg %0d phase %0d value", i, ph), grv(i), prev);
                chk("R9", $sformatf("reg %0d phase %0d pulse", i, ph), capt, 1 << i);
                @(negedge clk);
                chk("R9", $sformatf("reg %0d phase %0d pulse ends", i, ph), capt, 0);
                wait_n(3);
            end
        end
        // R4: wrong edge ignored for capture
        cap_edge = 2'd1;
        seen = 0;
        @(negedge clk);
        cap_in[0] = 1'b1;
        for (int c = 0; c < 8; c++) begin @(negedge clk); if (capt[0]) seen = 1; end
        chk("R4", "rising pin ignored in falling mode", seen, 0);
        cap_in[0] = 1'b0;
        wait_n(8);

        // R10: compare-mode register ignores capture pin
        cap_mode = '0; cap_edge = 2'd2;
        write_gr(2, 77);
        seen = 0;
        @(negedge clk);
        cap_in[2] = 1'b1;
        for (int c = 0; c < 6; c++) begin @(negedge clk); if (capt != 0) seen = 1; end
        cap_in[2] = 1'b0;
        for (int c = 0; c < 6; c++) begin @(negedge clk); if (capt != 0) seen = 1; end
        chk("R10", "compare register unchanged by pin", grv(2), 77);
        chk("R10", "no capture pulse in compare mode", seen, 0);

        // R10: write coinciding with capture wins
        cap_mode = 4'b0010; cap_edge = 2'd0;
        @(negedge clk);
        cap_in[1] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        gr_wr[1] = 1'b1; wdata = 8'd33;
        @(negedge clk);
        gr_wr = '0;
        chk("R10", "write wins over capture", grv(1), 33);
        chk("R10", "capture pulse suppressed", capt, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule